// File: doc/BRIEF.md
# Receive Early-Warning and Discard Controller

This block sits beside one receive packet path and watches the strobes that path produces while it fills buffer memory. It counts the bytes written for the packet now in progress. When that count goes past a programmable threshold, it raises an early-receive flag so software can start work on the packet before it is complete.

Software can also abort the packet being received by writing a self-clearing discard request. The request wins only if the packet is still open. If it wins, the packet ends with an overrun flag. If it comes too late, the packet ends normally with a receive flag. Separately, an 8-bit counter records packets dropped because an external discard input was high when they ended. Reading the counter clears it. The counter wraps, and it raises its own flag when it reaches its top value.

Software reaches the block through a small register port with three addresses:

| Address | Contents | Access |
|---|---|---|
| 0 | Threshold in bits [THR_W-1:0]; bit 7 is the discard request | Read/write |
| 1 | Drop counter | Read clears it |
| 2 | Interrupt flags | Write 1 to a bit to clear it |

Top module: `rx_early_discard_ctrl`

## Requirements
- R1: After reset, the threshold field reads 31, the flag register reads 0x00, the drop counter reads 0x00, and `irq` is low.
- R2: Flag bit 5 (early receive) sets once the number of bytes written for the current packet is strictly greater than threshold × 2^UNIT_LOG2. It does not set when the count only equals that value. The default unit is 64 bytes. A threshold of 0 fires on the first byte.
- R3: The byte count restarts at each `pkt_start`. Flag bit 5 sets at most once per packet: if software clears it during the same packet, further bytes do not set it again.
- R4: A write to address 0 with bit 7 set, while a packet is open and `pkt_end` is low, does four things:
  - `pkt_abort` pulses in that same cycle.
  - Flag bit 4 (overrun) sets.
  - The packet's remaining bytes and its end strobe are ignored.
  - Flag bit 0 is not set for that packet.
- R5: A discard request has no effect in two cases: when no packet is open, and when it arrives in the same cycle as `pkt_end`. In both cases no abort occurs and the packet completes normally. Bit 7 of address 0 always reads 0.
- R6: A packet that ends normally, with `ext_discard` low at `pkt_end`, sets flag bit 0 (receive).
- R7: A packet whose `pkt_end` arrives with `ext_discard` high increments the drop counter and sets no flag.
- R8: A read of address 1 returns the counter value and clears it to 0x00. If an increment happens in the same cycle, the read returns the value before the increment and the counter becomes 0x01.
- R9: When the drop counter steps to 0xFF, flag bit 6 sets. The next increment wraps the counter to 0x00.
- R10: Flags stay set until software writes 1 to their bit positions at address 2. `irq` is high exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 1 clears the drop counter |
| reg_addr | input | 2 | Register address: 0 control/threshold, 1 drop counter, 2 flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the addressed register |
| pkt_start | input | 1 | Opens a new packet and restarts its byte count |
| byte_wr | input | 1 | One byte of the open packet written to buffer memory this cycle |
| pkt_end | input | 1 | Closes the open packet |
| ext_discard | input | 1 | Sampled at `pkt_end`; high means the packet is dropped and counted |
| pkt_abort | output | 1 | One-cycle pulse when a software discard aborts the open packet |
| irq_flags | output | 8 | Flags: bit 0 receive, bit 4 overrun, bit 5 early receive, bit 6 drop counter full |
| irq | output | 1 | OR of all flags |

## Verification
The bench builds the block with UNIT_LOG2 = 2 and BCNT_W = 10, so the threshold is counted in 4-byte units. With that setting, the largest threshold (31, or 124 bytes) and the equal-versus-exceed boundary at both ends of the threshold range can be reached with packets of a few dozen to a couple of hundred bytes. DROP_W keeps its default of 8. This lets the bench walk the drop counter through 0xFF and the wrap to 0x00, and cover the read-clear collision, in a few hundred short packets.

// File: rtl/rxed_pkg.sv
package rxed_pkg;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_DROP = 2'd1,
    RA_STAT = 2'd2,
    RA_NONE = 2'd3
  } rxed_addr_e;

  localparam int unsigned DATA_W        = 8;
  localparam int unsigned FB_RCV        = 0;
  localparam int unsigned FB_OVRN       = 4;
  localparam int unsigned FB_ERCV       = 5;
  localparam int unsigned FB_DFULL      = 6;
  localparam int unsigned CTRL_DISC_BIT = 7;

endpackage

// File: rtl/rxed_pkt_ctrl.sv
module rxed_pkt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_start,
  input  logic pkt_end,
  input  logic byte_wr,
  input  logic ext_discard,
  input  logic disc_req,
  output logic active,
  output logic byte_en,
  output logic abort,
  output logic done_ok,
  output logic done_drop
);

  logic active_q;
  logic active_d;
  logic active_en;

  // An abort is honoured only while the packet is open and its end has not arrived.
  always_comb begin
    abort     = disc_req & active_q & ~pkt_end & ~pkt_start;
    done_ok   = pkt_end & active_q & ~ext_discard;
    done_drop = pkt_end & active_q & ext_discard;
    byte_en   = byte_wr & (pkt_start | (active_q & ~abort));
    active_en = pkt_start | abort | pkt_end;
    if (pkt_start) begin
      active_d = 1'b1;
    end else begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (active_en) begin
      active_q <= active_d;
    end
  end

  assign active = active_q;

  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !active_q); // R4

endmodule

// File: rtl/rxed_byte_tracker.sv
module rxed_byte_tracker #(
  parameter int unsigned BCNT_W    = 16,
  parameter int unsigned THR_W     = 5,
  parameter int unsigned UNIT_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start,
  input  logic             byte_en,
  input  logic [THR_W-1:0] thr,
  output logic             early_hit
);

  localparam int unsigned CMP_W = BCNT_W + 1;
  localparam logic [BCNT_W-1:0] BCNT_MAX = '1;

  logic [BCNT_W-1:0] bcnt_q;
  logic [BCNT_W-1:0] bcnt_base;
  logic [BCNT_W-1:0] bcnt_d;
  logic              armed_q;
  logic              armed_base;
  logic              armed_d;
  logic              trk_en;
  logic [CMP_W-1:0]  thr_bytes;

  always_comb begin
    thr_bytes  = CMP_W'(thr) << UNIT_LOG2;
    bcnt_base  = pkt_start ? '0 : bcnt_q;
    armed_base = pkt_start | armed_q;
    bcnt_d     = bcnt_base;
    if (byte_en && (bcnt_base != BCNT_MAX)) begin
      bcnt_d = bcnt_base + 1'b1;
    end
    early_hit = byte_en & armed_base & ({1'b0, bcnt_d} > thr_bytes);
    armed_d   = armed_base & ~early_hit;
    trk_en    = pkt_start | byte_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q  <= '0;
      armed_q <= 1'b0;
    end else if (trk_en) begin
      bcnt_q  <= bcnt_d;
      armed_q <= armed_d;
    end
  end

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> (bcnt_q <= BCNT_W'(1))); // R3
  AST_ERCV_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    early_hit |=> (pkt_start || !early_hit)); // R3

endmodule

// File: rtl/rxed_drop_counter.sv
module rxed_drop_counter #(
  parameter int unsigned DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              rd_clr,
  output logic [DROP_W-1:0] cnt,
  output logic              full_hit
);

  localparam logic [DROP_W-1:0] CNT_MAX = '1;
  localparam logic [DROP_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

  logic [DROP_W-1:0] cnt_q;
  logic [DROP_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = inc | rd_clr;
    if (rd_clr) begin
      cnt_d = inc ? DROP_W'(1) : '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    full_hit = inc & ~rd_clr & (cnt_q == CNT_PRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  AST_DROP_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !inc) |=> (cnt_q == '0)); // R8
  AST_DROP_READ_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && inc) |=> (cnt_q == DROP_W'(1))); // R8
  AST_DROP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !rd_clr && cnt_q == CNT_MAX) |=> (cnt_q == '0)); // R9
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full_hit |=> (cnt_q == CNT_MAX)); // R9

endmodule

// File: rtl/rx_early_discard_ctrl.sv
module rx_early_discard_ctrl
  import rxed_pkg::*;
#(
  parameter int unsigned THR_W     = 5,
  parameter int unsigned THR_RST   = 31,
  parameter int unsigned UNIT_LOG2 = 6,
  parameter int unsigned BCNT_W    = 16,
  parameter int unsigned DROP_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pkt_start,
  input  logic              byte_wr,
  input  logic              pkt_end,
  input  logic              ext_discard,
  output logic              pkt_abort,
  output logic [DATA_W-1:0] irq_flags,
  output logic              irq
);

  localparam logic [DATA_W-1:0] FLAG_MASK =
    DATA_W'((1 << FB_RCV) | (1 << FB_OVRN) | (1 << FB_ERCV) | (1 << FB_DFULL));

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q;
  logic rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_i      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_i      <= rst_meta_q;
    end
  end

  logic              ctrl_wr;
  logic              stat_wr;
  logic              drop_rd;
  logic              disc_req;
  logic              pkt_active;
  logic              byte_en;
  logic              abort;
  logic              done_ok;
  logic              done_drop;
  logic              early_hit;
  logic              full_hit;
  logic [DROP_W-1:0] drop_cnt;
  logic [THR_W-1:0]  thr_q;
  logic [DATA_W-1:0] flags_q;
  logic [DATA_W-1:0] flags_d;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;
  logic              flags_en;

  always_comb begin
    ctrl_wr  = reg_wr & (reg_addr == RA_CTRL);
    stat_wr  = reg_wr & (reg_addr == RA_STAT);
    drop_rd  = reg_rd & (reg_addr == RA_DROP);
    disc_req = ctrl_wr & reg_wdata[CTRL_DISC_BIT];
  end

  rxed_pkt_ctrl u_pkt (
    .clk         (clk),
    .rst_n       (rst_i),
    .pkt_start   (pkt_start),
    .pkt_end     (pkt_end),
    .byte_wr     (byte_wr),
    .ext_discard (ext_discard),
    .disc_req    (disc_req),
    .active      (pkt_active),
    .byte_en     (byte_en),
    .abort       (abort),
    .done_ok     (done_ok),
    .done_drop   (done_drop)
  );

  rxed_byte_tracker #(
    .BCNT_W    (BCNT_W),
    .THR_W     (THR_W),
    .UNIT_LOG2 (UNIT_LOG2)
  ) u_trk (
    .clk       (clk),
    .rst_n     (rst_i),
    .pkt_start (pkt_start),
    .byte_en   (byte_en),
    .thr       (thr_q),
    .early_hit (early_hit)
  );

  rxed_drop_counter #(
    .DROP_W (DROP_W)
  ) u_drop (
    .clk      (clk),
    .rst_n    (rst_i),
    .inc      (done_drop),
    .rd_clr   (drop_rd),
    .cnt      (drop_cnt),
    .full_hit (full_hit)
  );

  // Threshold register.
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      thr_q <= THR_W'(THR_RST);
    end else if (ctrl_wr) begin
      thr_q <= reg_wdata[THR_W-1:0];
    end
  end

  // Flag register: a new event wins over a clear in the same cycle.
  always_comb begin
    set_vec           = '0;
    set_vec[FB_RCV]   = done_ok;
    set_vec[FB_OVRN]  = abort;
    set_vec[FB_ERCV]  = early_hit;
    set_vec[FB_DFULL] = full_hit;
    clr_vec           = stat_wr ? reg_wdata : '0;
    flags_d           = ((flags_q & ~clr_vec) | set_vec) & FLAG_MASK;
    flags_en          = (|set_vec) | stat_wr;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: reg_rdata = DATA_W'(thr_q);
      RA_DROP: reg_rdata = DATA_W'(drop_cnt);
      RA_STAT: reg_rdata = flags_q;
      default: reg_rdata = '0;
    endcase
  end

  assign pkt_abort = abort;
  assign irq_flags = flags_q;
  assign irq       = |flags_q;

  AST_RCV_ON_END: assert property (@(posedge clk) disable iff (!rst_i)
    done_ok |=> irq_flags[FB_RCV]); // R6
  AST_OVRN_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_i)
    pkt_abort |=> irq_flags[FB_OVRN]); // R4
  AST_IDLE_DISC_NOP: assert property (@(posedge clk) disable iff (!rst_i)
    (disc_req && !pkt_active) |-> !pkt_abort); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    (irq_flags[FB_OVRN] && !stat_wr) |=> irq_flags[FB_OVRN]); // R10

endmodule

// File: tb/tb_rx_early_discard_ctrl.sv
`timescale 1ns/1ps
module tb_rx_early_discard_ctrl;

  localparam int unsigned UL2  = 2;
  localparam int unsigned NVEC = 7;
  // Each entry packs {expect_early(1), threshold(5), byte_count(8)}.
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 5'd2,  8'd8},
    {1'b1, 5'd2,  8'd9},
    {1'b0, 5'd0,  8'd0},
    {1'b1, 5'd0,  8'd1},
    {1'b0, 5'd31, 8'd124},
    {1'b1, 5'd31, 8'd125},
    {1'b1, 5'd5,  8'd200}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       pkt_start, byte_wr, pkt_end, ext_discard;
  logic       pkt_abort, irq;
  logic [7:0] irq_flags;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rx_early_discard_ctrl #(.UNIT_LOG2(UL2), .BCNT_W(10)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pkt_start(pkt_start), .byte_wr(byte_wr), .pkt_end(pkt_end),
    .ext_discard(ext_discard), .pkt_abort(pkt_abort),
    .irq_flags(irq_flags), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic p_begin();
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
  endtask

  task automatic p_bytes(input int n);
    byte_wr = 1'b1;
    repeat (n) @(negedge clk);
    byte_wr = 1'b0;
  endtask

  task automatic p_finish(input logic ext);
    pkt_end = 1'b1; ext_discard = ext;
    @(negedge clk);
    pkt_end = 1'b0; ext_discard = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    pkt_start = 0; byte_wr = 0; pkt_end = 0; ext_discard = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 threshold", d, 8'd31);
    rd(2'd2, d); chk("R1 flags", d, 8'h00);
    rd(2'd1, d); chk("R1 drop count", d, 8'h00);
    chk("R1 irq", irq, 1'b0);

    // R2 table walk: threshold boundary, plus R6 normal completion
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, {3'b000, VEC[i][12:8]});
      p_begin();
      p_bytes(int'(VEC[i][7:0]));
      p_finish(1'b0);
      rd(2'd2, d);
      chk($sformatf("R2 R6 vector %0d", i), d, {2'b00, VEC[i][13], 5'b00001});
      wr(2'd2, 8'hFF);
    end

    // R3 once per packet, R10 write-one-to-clear
    wr(2'd0, 8'd1);
    p_begin();
    p_bytes(6);
    rd(2'd2, d); chk("R3 early set mid packet", d, 8'h20);
    chk("R10 irq follows flag", irq, 1'b1);
    wr(2'd2, 8'h20);
    chk("R10 irq after clear", irq, 1'b0);
    p_bytes(10);
    rd(2'd2, d); chk("R3 no second early", d, 8'h00);
    p_finish(1'b0);
    repeat (3) @(negedge clk);
    rd(2'd2, d); chk("R10 flag holds", d, 8'h01);
    wr(2'd2, 8'h01);
    p_begin(); p_bytes(3); p_finish(1'b0);
    rd(2'd2, d); chk("R3 count restarts", d, 8'h01);
    wr(2'd2, 8'hFF);

    // R4 abort an open packet
    wr(2'd0, 8'd31);
    p_begin(); p_bytes(3);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h9F;
    #1 chk("R4 abort pulse", pkt_abort, 1'b1);
    @(negedge clk); reg_wr = 1'b0;
    p_bytes(200); p_finish(1'b0);
    rd(2'd2, d); chk("R4 overrun only", d, 8'h10);
    wr(2'd2, 8'hFF);

    // R5 discard while idle, and in the cycle of pkt_end
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h9F;
    #1 chk("R5 idle no abort", pkt_abort, 1'b0);
    @(negedge clk); reg_wr = 1'b0;
    rd(2'd2, d); chk("R5 idle no flag", d, 8'h00);
    rd(2'd0, d); chk("R5 request bit reads 0", d, 8'd31);
    p_begin(); p_bytes(2); p_finish(1'b0);
    rd(2'd2, d); chk("R5 next packet normal", d, 8'h01);
    wr(2'd2, 8'hFF);
    p_begin(); p_bytes(2);
    pkt_end = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h9F;
    #1 chk("R5 late request no abort", pkt_abort, 1'b0);
    @(negedge clk); pkt_end = 1'b0; reg_wr = 1'b0;
    rd(2'd2, d); chk("R5 late request completes", d, 8'h01);
    wr(2'd2, 8'hFF);

    // R7 external discard, R8 read clears
    p_begin(); p_bytes(4); p_finish(1'b1);
    rd(2'd2, d); chk("R7 no flag", d, 8'h00);
    rd(2'd1, d); chk("R7 counted", d, 8'h01);
    rd(2'd1, d); chk("R8 cleared by read", d, 8'h00);

    // R8 read in the same cycle as an increment
    p_begin(); p_finish(1'b1);
    p_begin();
    pkt_end = 1'b1; ext_discard = 1'b1; reg_rd = 1'b1; reg_addr = 2'd1;
    #1 chk("R8 read returns prior value", reg_rdata, 8'h01);
    @(negedge clk); pkt_end = 1'b0; ext_discard = 1'b0; reg_rd = 1'b0;
    rd(2'd1, d); chk("R8 collision leaves one", d, 8'h01);

    // R9 full flag and wrap
    for (int k = 0; k < 254; k++) begin
      p_begin(); p_finish(1'b1);
    end
    rd(2'd2, d); chk("R9 no flag at 0xFE", d, 8'h00);
    p_begin(); p_finish(1'b1);
    rd(2'd2, d); chk("R9 full flag", d, 8'h40);
    chk("R10 irq on full", irq, 1'b1);
    p_begin(); p_finish(1'b1);
    rd(2'd1, d); chk("R9 wrapped", d, 8'h00);
    wr(2'd2, 8'h40);
    chk("R10 irq cleared", irq, 1'b0);

    finish_run();
  end

endmodule